// File: doc/BRIEF.md
# Per-Core Private Countdown Timer

This block is a small countdown timer meant to sit beside each processor core, once for the periodic timer slot and once for the watchdog slot. Software programs it through four 32-bit registers behind a simple write port with a combinational read path. A byte offset on `bus_addr` picks one of them: the reload value, the live count, the control word or the interrupt status. The counter steps down once every (prescaler + 1) clock cycles. The clock itself serves as the base tick.

When the count runs out, the timer sets a sticky status flag. It then either refills itself from the reload value and keeps running, or stays at zero and stops. The interrupt line gives a single-cycle pulse, and only when the status flag goes from clear to set. A flag that is already set and expires again gives no new pulse until software clears it. Writing the reload register also overwrites the live count. Turning on the enable bit while the count is zero and auto-reload is selected refills the counter first.

Top module: `cdt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_pulse` is low.
- R2: A write to offset 0x0 stores the value as the reload value and also as the live count. A write to offset 0x4 changes only the live count. Offset 0x0 reads back the reload value.
- R3: Control bits 15:8 hold a prescaler P, and an enabled, non-zero count drops by one every P+1 cycles. The prescale phase restarts on any write to offset 0x0 or 0x4, and on an enable rising edge. So a count of N written at a clock edge expires N*(P+1) edges later.
- R4: The counter expires when it steps down from 1. Expiry sets status bit 0. If control bit 1 (auto-reload) is set, the count is refilled from the reload value and counting goes on.
- R5: When the counter expires with auto-reload clear, the count stays at zero and stops. A zero count never produces an expiry, even while enabled.
- R6: A control write that changes bit 0 (enable) from 0 to 1 copies the reload value into the count, but only if the count is zero and the written bit 1 is set.
- R7: Reading offset 0x4 returns 0 while enable is clear or the count is zero, and returns the remaining count otherwise. The count is held, not lost, while the timer is disabled.
- R8: The status register at offset 0xC reads as bit 0 = flag. Writing a 1 in bit 0 clears the flag, and writing 0 leaves it. An expiry in the same cycle as a clear leaves the flag set.
- R9: `irq_pulse` is high for exactly one cycle. It rises at the same clock edge at which the status flag goes from 0 to 1, and it never rises when the flag was already set.
- R10: Offset 0x8 reads back the full control word as last written. Accesses with `bus_addr[1:0]` not zero are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one base tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register addressed by `bus_addr` |
| bus_addr | input | 4 | Byte offset of the register (0x0, 0x4, 0x8, 0xC) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| irq_pulse | output | 1 | One-cycle pulse when the status flag becomes set |

## Verification
The bench builds the block with its default parameters: 32-bit registers and an 8-bit prescaler in control bits 15:8. The random stimulus keeps counts at 12 or below and prescalers at 3 or below. Repeated expiry, reload, stop-at-zero, clears that collide with expiry, and re-enables with a zero count all therefore occur many times within a few thousand cycles. Counts near the top of the 32-bit range are written and read back, but they are never counted out.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STAT   = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_AUTO_BIT = 1;
  localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         step
);
  logic [W-1:0] phase_q;
  logic [W-1:0] phase_d;
  logic         phase_en;

  always_comb begin
    step     = run && !restart && (phase_q >= limit);
    phase_en = restart || run;
    if (restart || step) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_val,
  input  logic [W-1:0] wr_data,
  input  logic         arm_load,
  input  logic [W-1:0] reload_val,
  input  logic         auto_reload,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    expire = step && (cnt_q == W'(1));
    cnt_en = wr_val || arm_load || step;
    if (wr_val) begin
      cnt_d = wr_data;
    end else if (arm_load) begin
      cnt_d = reload_val;
    end else if (expire) begin
      cnt_d = auto_reload ? reload_val : '0;
    end else begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cdt_irq_edge.sv
module cdt_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clear,
  output logic status,
  output logic irq
);
  logic flag_q;
  logic flag_d;
  logic irq_q;
  logic irq_d;

  always_comb begin
    flag_d = expire || (flag_q && !clear);
    irq_d  = expire && !flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign status = flag_q;
  assign irq    = irq_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int PSC_LSB = 8,
  parameter int PSC_W   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_pulse
);
  localparam int PSC_MSB = PSC_LSB + PSC_W - 1;

  reg_sel_e      sel;
  logic          aligned;
  logic          wr_reload;
  logic          wr_count;
  logic          wr_ctrl;
  logic          wr_stat;
  logic          enable_rise;
  logic          restart;
  logic          run;
  logic          arm_load;
  logic          clear;
  logic          step;
  logic          expire;
  logic          stat;
  logic [DW-1:0] cnt;
  logic [DW-1:0] load_q;
  logic [DW-1:0] ctrl_q;

  always_comb begin
    aligned     = (bus_addr[1:0] == 2'b00);
    sel         = reg_sel_e'(bus_addr[3:2]);
    wr_reload   = bus_wr && aligned && (sel == SEL_RELOAD);
    wr_count    = bus_wr && aligned && (sel == SEL_COUNT);
    wr_ctrl     = bus_wr && aligned && (sel == SEL_CTRL);
    wr_stat     = bus_wr && aligned && (sel == SEL_STAT);
    enable_rise = wr_ctrl && !ctrl_q[CTRL_RUN_BIT] && bus_wdata[CTRL_RUN_BIT];
    restart     = wr_reload || wr_count || enable_rise;
    run         = ctrl_q[CTRL_RUN_BIT] && (cnt != '0);
    arm_load    = enable_rise && bus_wdata[CTRL_AUTO_BIT] && (cnt == '0);
    clear       = wr_stat && bus_wdata[STAT_FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (wr_reload) begin
      load_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata;
    end
  end

  cdt_prescaler #(.W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .limit   (ctrl_q[PSC_MSB:PSC_LSB]),
    .step    (step)
  );

  cdt_counter #(.W(DW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_val      (wr_reload || wr_count),
    .wr_data     (bus_wdata),
    .arm_load    (arm_load),
    .reload_val  (load_q),
    .auto_reload (ctrl_q[CTRL_AUTO_BIT]),
    .step        (step),
    .cnt         (cnt),
    .expire      (expire)
  );

  cdt_irq_edge u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .clear  (clear),
    .status (stat),
    .irq    (irq_pulse)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (sel)
        SEL_RELOAD: bus_rdata = load_q;
        SEL_COUNT:  bus_rdata = (ctrl_q[CTRL_RUN_BIT] && (cnt != '0)) ? cnt : '0;
        SEL_CTRL:   bus_rdata = ctrl_q;
        SEL_STAT:   bus_rdata = {{(DW-1){1'b0}}, stat};
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [3:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          irq_pulse,
  input logic          stat,
  input logic          expire,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] load_q,
  input logic [DW-1:0] ctrl_q
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R9

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (stat && !$past(stat))); // R9

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !(bus_wr && bus_addr == 4'hC && bus_wdata[0])) |=> stat); // R8

  AST_RELOAD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'h0) |=> (cnt == $past(bus_wdata) && load_q == $past(bus_wdata))); // R2

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'h4 && (!ctrl_q[0] || cnt == '0)) |-> (bus_rdata == '0)); // R7

  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q[1] && !bus_wr) |=> (cnt == '0)); // R5
endmodule

bind cdt_timer cdt_timer_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_pulse (irq_pulse),
  .stat      (stat),
  .expire    (expire),
  .cnt       (cnt),
  .load_q    (load_q),
  .ctrl_q    (ctrl_q)
);

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_pulse;

  int n_checks;
  int n_bad;

  logic [31:0] m_load, m_cnt, m_ctrl;
  logic [7:0]  m_pre;
  logic        m_st, m_irq;

  cdt_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[3:2])
      2'd0:    return m_load;
      2'd1:    return (m_ctrl[0] && m_cnt != 0) ? m_cnt : 32'h0;
      2'd2:    return m_ctrl;
      default: return {31'h0, m_st};
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a[1:0] != 2'b00) return "R10 misaligned read";
    case (a[3:2])
      2'd0:    return "R2 reload read";
      2'd1:    return "R7 count read";
      2'd2:    return "R10 control read";
      default: return "R8 status read";
    endcase
  endfunction

  task automatic model_step();
    logic ok, wl, wc, wk, ws, rise, restart, run, step, expv;
    logic [31:0] ncnt;
    ok      = bus_wr && (bus_addr[1:0] == 2'b00);
    wl      = ok && bus_addr[3:2] == 2'd0;
    wc      = ok && bus_addr[3:2] == 2'd1;
    wk      = ok && bus_addr[3:2] == 2'd2;
    ws      = ok && bus_addr[3:2] == 2'd3;
    rise    = wk && !m_ctrl[0] && bus_wdata[0];
    restart = wl || wc || rise;
    run     = m_ctrl[0] && m_cnt != 0;
    step    = run && !restart && (m_pre >= m_ctrl[15:8]);
    expv    = step && m_cnt == 1;
    if (wl || wc) ncnt = bus_wdata;
    else if (rise && bus_wdata[1] && m_cnt == 0) ncnt = m_load;
    else if (expv) ncnt = m_ctrl[1] ? m_load : 32'h0;
    else if (step) ncnt = m_cnt - 1;
    else ncnt = m_cnt;
    if (restart || step) m_pre = 8'h0;
    else if (run) m_pre = m_pre + 8'h1;
    m_irq = expv && !m_st;
    m_st  = expv || (m_st && !(ws && bus_wdata[0]));
    m_cnt = ncnt;
    if (wl) m_load = bus_wdata;
    if (wk) m_ctrl = bus_wdata;
  endtask

  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d);
    bus_wr    = wr;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R9 irq pulse", {31'h0, irq_pulse}, {31'h0, m_irq});
    chk(tag_of(a), bus_rdata, exp_read(a));
  endtask

  task automatic idle(input logic [3:0] a);
    cyc(1'b0, a, 32'h0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int irq_seen;
    void'($urandom(32'd5521));
    n_checks = 0;
    n_bad    = 0;
    m_load = 0; m_cnt = 0; m_ctrl = 0; m_pre = 0; m_st = 0; m_irq = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      bus_addr = 4'(i * 4);
      #1;
      chk("R1 reset read", bus_rdata, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq_pulse}, 32'h0);

    // R3: prescaler 2, count 3 -> expiry 9 edges after the count write
    cyc(1'b1, 4'h8, 32'h0000_0201);
    cyc(1'b1, 4'h4, 32'd3);
    irq_seen = 0;
    for (int k = 1; k <= 9; k++) begin
      idle(4'h4);
      if (irq_pulse) irq_seen = k;
    end
    chk("R3 expiry edge", irq_seen, 9);
    // R5: stopped at zero, no further pulse
    chk("R5 count zero after stop", bus_rdata, 32'h0);
    irq_seen = 0;
    for (int k = 0; k < 12; k++) begin
      idle(4'hC);
      if (irq_pulse) irq_seen++;
    end
    chk("R5 no expiry from zero", irq_seen, 0);
    chk("R8 flag sticky", bus_rdata, 32'h1);
    cyc(1'b1, 4'hC, 32'h0);
    chk("R8 write zero keeps flag", bus_rdata, 32'h1);
    cyc(1'b1, 4'hC, 32'h1);
    chk("R8 write one clears", bus_rdata, 32'h0);

    // R4: auto-reload, prescaler 0, reload 4
    cyc(1'b1, 4'h8, 32'h0);
    cyc(1'b1, 4'h0, 32'd4);
    cyc(1'b1, 4'h8, 32'h0000_0003);
    idle(4'h4); idle(4'h4); idle(4'h4);
    chk("R4 count before expiry", bus_rdata, 32'd1);
    idle(4'h4);
    chk("R4 reloaded", bus_rdata, 32'd4);
    idle(4'hC);
    chk("R4 flag set", bus_rdata, 32'h1);

    // R6: enable edge with zero count pulls in the reload value
    cyc(1'b1, 4'h8, 32'h0);
    cyc(1'b1, 4'h0, 32'd7);
    cyc(1'b1, 4'h4, 32'd0);
    cyc(1'b1, 4'h8, 32'h0000_0103);
    chk("R6 armed from reload", bus_rdata, 32'h0000_0103);
    idle(4'h4);
    chk("R6 count loaded", bus_rdata, 32'd7);

    // R7: disabled reads zero, count held
    cyc(1'b1, 4'h8, 32'h0000_0102);
    cyc(1'b1, 4'h4, 32'd5);
    chk("R7 disabled reads zero", bus_rdata, 32'h0);
    idle(4'h4); idle(4'h4);
    cyc(1'b1, 4'h8, 32'h0000_0101);
    idle(4'h4);
    chk("R7 held count", bus_rdata, 32'd5);

    // R2 / R10: wide values and misaligned writes
    cyc(1'b1, 4'h8, 32'h0);
    cyc(1'b1, 4'h0, 32'hFFFF_FFF0);
    idle(4'h0);
    chk("R2 reload stored", bus_rdata, 32'hFFFF_FFF0);
    cyc(1'b1, 4'h4, 32'd9);
    idle(4'h0);
    chk("R2 count write leaves reload", bus_rdata, 32'hFFFF_FFF0);
    cyc(1'b1, 4'h1, 32'h1234_5678);
    idle(4'h0);
    chk("R10 misaligned write ignored", bus_rdata, 32'hFFFF_FFF0);

    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 11);
      case (op)
        0: cyc(1'b1, 4'h0, 32'($urandom_range(0, 12)));
        1: cyc(1'b1, 4'h4, 32'($urandom_range(0, 12)));
        2: begin
          d = {16'($urandom_range(0, 3)), 6'h0, 2'($urandom_range(0, 3)), 6'h0, 2'($urandom_range(0, 3))};
          d[15:10] = 6'h0;
          cyc(1'b1, 4'h8, d);
        end
        3: cyc(1'b1, 4'hC, 32'($urandom_range(0, 3)));
        4: cyc(1'b1, 4'($urandom_range(1, 15)) | 4'h1, $urandom);
        default: idle(4'($urandom_range(0, 3) * 4));
      endcase
    end

    finish_run();
  end
endmodule